// File: doc/BRIEF.md
# Pulse-Pause Reader Frame Demodulator

This block recovers frames that a reader sends to a tag over a single digital carrier line. Low means the reader is pausing the field and high means the field is on. A bit carries no clock of its own. Its value comes from the spacing between the starts of two successive pauses, counted in ticks of a slow enable (`tick`, nominally a 212 kHz subcarrier rate). A frame has no length field. It ends at the first code violation: a gap that is too short, or a pause or pulse that runs past the deadline.

After `arm`, the block waits for the first pause in windows of 21 ticks. It asks an external scrambler to advance once at the start of each window, and it gives up with an error after 122 empty windows. Each decoded bit is XORed with the scrambler's current keystream bit and placed LSB-first, and the scrambler is then advanced. When the frame ends, the block raises a one-cycle valid or error strobe. The word, the bit count and an end-of-frame timestamp stay on the outputs for whatever follows, for example the timing of a reply.

Top module: `pp_frame_demod`

## Requirements
- R1: After reset `ks_adv`, `frame_valid` and `frame_error` are low, and `frame_word`, `frame_len` and `end_stamp` are zero. The tick count used for time stamps starts at zero when reset is released and advances by one on each cycle in which `tick` is high.
- R2: When `arm` is seen while idle, the block starts waiting and pulses `ks_adv` at once. It pulses `ks_adv` again each time 21 ticks pass without a pause. If the first pause follows D ticks after arm, exactly floor(D/21)+1 advances come before the first bit.
- R3: If 122 windows pass with no pause, `frame_error` pulses with `frame_len` 0 and `end_stamp` unchanged. The keystream has then advanced 122 times.
- R4: A bit spans the interval from one pause start (falling edge) to the next. An interval longer than 17 ticks decodes as 1, and an interval of 4 to 17 ticks decodes as 0.
- R5: Each decoded bit is XORed with `ks_bit` and written to `frame_word` bit position `frame_len`, so bit 0 is the first received. `frame_len` then increments, and `ks_adv` pulses once per bit.
- R6: If the pause does not end, or the next pause does not begin, within 31 ticks of a pause start (the 32nd tick), the frame ends.
- R7: A new pause that begins less than 4 ticks after the previous pause start ends the frame, and that bit is not stored.
- R8: At frame end, `frame_valid` pulses if 6 to 23 bits were received and `frame_error` pulses otherwise. Bits of `frame_word` at positions at or above the length are zero.
- R9: At frame end, `end_stamp` is the tick count of the last pause start plus 2. For an R7 end, the last pause start is the violating one.
- R10: While idle (not armed), pauses on `carrier` cause no strobe and no `ks_adv`.
- R11: `frame_valid` and `frame_error` never assert together and each lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at the subcarrier rate; all timing counts these |
| arm | input | 1 | Start waiting for a frame (sampled while idle) |
| carrier | input | 1 | Asynchronous field level: 0 pause, 1 pulse |
| ks_bit | input | 1 | Current keystream bit from the scrambler |
| ks_adv | output | 1 | One-cycle request to advance the scrambler |
| frame_word | output | 24 | Descrambled frame, first bit in bit 0 |
| frame_len | output | 5 | Number of bits received |
| frame_valid | output | 1 | Frame ended with an accepted length |
| frame_error | output | 1 | Frame ended with a bad length, or the wait timed out |
| end_stamp | output | 16 | Tick count of the frame end |

## Verification
The hardest cases to reach are those where the keystream position depends on how long the block idled before the first pause. The position shifts with every 21-tick window, so a frame that starts one tick too late is descrambled entirely differently. The bench therefore places the first pause at chosen tick offsets after arm, including an exact window boundary and a wait of dozens of windows. It counts scrambler advances itself. It drives interval lengths at the 4/17/18/31-tick edges and ends frames in each of the three violation ways, with lengths around both limits.

// File: rtl/pp_frame_demod.sv
module pp_frame_demod #(
  parameter int TW        = 16,
  parameter int WORD_W    = 24,
  parameter int LEN_W     = 5,
  parameter int PAUSE_T   = 4,
  parameter int ZERO_T    = 13,
  parameter int ONE_T     = 21,
  parameter int MIN_LEN   = 6,
  parameter int MAX_LEN   = 23,
  parameter int WIN_LIMIT = 120,
  parameter int PIPE_ADJ  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              arm,
  input  logic              carrier,
  input  logic              ks_bit,
  output logic              ks_adv,
  output logic [WORD_W-1:0] frame_word,
  output logic [LEN_W-1:0]  frame_len,
  output logic              frame_valid,
  output logic              frame_error,
  output logic [TW-1:0]     end_stamp
);

  localparam int WT_W = $clog2(ONE_T);
  localparam int WX_W = $clog2(WIN_LIMIT + 2);
  localparam logic [TW-1:0]    DEADLINE = TW'(ONE_T * 3 / 2);
  localparam logic [TW-1:0]    THRESH   = TW'((ZERO_T + ONE_T) / 2);
  localparam logic [TW-1:0]    MIN_IV   = TW'(PAUSE_T);
  localparam logic [TW-1:0]    ST_ADJ   = TW'(PAUSE_T - PIPE_ADJ);
  localparam logic [WT_W-1:0]  WT_LAST  = WT_W'(ONE_T - 1);
  localparam logic [WX_W-1:0]  WX_LAST  = WX_W'(WIN_LIMIT + 1);
  localparam logic [LEN_W-1:0] LMIN     = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LMAX     = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LWORD    = LEN_W'(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LOW, S_HIGH} st_t;
  st_t st;

  logic [2:0]      sync;
  logic [TW-1:0]   now, bit_start;
  logic [WT_W-1:0] wtick;
  logic [WX_W-1:0] widx;

  wire          fall   = sync[2] & ~sync[1];
  wire          rise   = ~sync[2] & sync[1];
  wire [TW-1:0] el     = now - bit_start;
  wire          over   = el > DEADLINE;
  wire          len_ok = (frame_len >= LMIN) && (frame_len <= LMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 3'b111;
      now  <= '0;
    end else begin
      sync <= {sync[1:0], carrier};
      if (tick) now <= now + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bit_start   <= '0;
      wtick       <= '0;
      widx        <= '0;
      ks_adv      <= 1'b0;
      frame_word  <= '0;
      frame_len   <= '0;
      frame_valid <= 1'b0;
      frame_error <= 1'b0;
      end_stamp   <= '0;
    end else begin
      ks_adv      <= 1'b0;
      frame_valid <= 1'b0;
      frame_error <= 1'b0;
      case (st)
        S_IDLE: if (arm) begin
          st         <= S_WAIT;
          ks_adv     <= 1'b1;
          wtick      <= '0;
          widx       <= '0;
          frame_word <= '0;
          frame_len  <= '0;
        end
        S_WAIT: begin
          if (fall) begin
            bit_start <= now;
            st        <= S_LOW;
          end else if (tick) begin
            if (wtick == WT_LAST) begin
              wtick <= '0;
              if (widx == WX_LAST) begin
                frame_error <= 1'b1;
                st          <= S_IDLE;
              end else begin
                widx   <= widx + 1'b1;
                ks_adv <= 1'b1;
              end
            end else begin
              wtick <= wtick + 1'b1;
            end
          end
        end
        S_LOW: begin
          if (rise) begin
            st <= S_HIGH;
          end else if (over) begin
            st          <= S_IDLE;
            end_stamp   <= bit_start + ST_ADJ;
            frame_valid <= len_ok;
            frame_error <= !len_ok;
          end
        end
        S_HIGH: begin
          if (fall) begin
            if (el < MIN_IV) begin
              st          <= S_IDLE;
              end_stamp   <= now + ST_ADJ;
              frame_valid <= len_ok;
              frame_error <= !len_ok;
            end else begin
              if (frame_len < LWORD) frame_word[frame_len] <= (el > THRESH) ^ ks_bit;
              if (frame_len != {LEN_W{1'b1}}) frame_len <= frame_len + 1'b1;
              ks_adv    <= 1'b1;
              bit_start <= now;
              st        <= S_LOW;
            end
          end else if (over) begin
            st          <= S_IDLE;
            end_stamp   <= bit_start + ST_ADJ;
            frame_valid <= len_ok;
            frame_error <= !len_ok;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && frame_error));
  // R11
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid || frame_error) |=> !(frame_valid || frame_error));
  // R8
  valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_len >= LMIN) && (frame_len <= LMAX));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !arm) |=> (!ks_adv && !frame_valid && !frame_error));
  // R2
  arm_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && arm) |=> ks_adv);

endmodule

// File: tb/pp_frame_demod_test.sv
module pp_frame_demod_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, arm = 1'b0, carrier = 1'b1;
  logic ks_bit, ks_adv, frame_valid, frame_error;
  logic [23:0] frame_word;
  logic [4:0]  frame_len;
  logic [15:0] end_stamp;

  int checks = 0, fails = 0, nstb = 0, kcnt = 0, ph = 0;
  logic [15:0] bnow = '0;
  logic cv, ce;
  logic [23:0] cw;
  logic [4:0]  cl;
  logic [15:0] cs;
  int iv [0:31];

  always #2.5 clk = ~clk;

  pp_frame_demod uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .carrier(carrier),
    .ks_bit(ks_bit), .ks_adv(ks_adv), .frame_word(frame_word), .frame_len(frame_len),
    .frame_valid(frame_valid), .frame_error(frame_error), .end_stamp(end_stamp));

  function automatic logic kf(int k);
    logic [31:0] h;
    h = k * 32'h9E37_79B1;
    return h[16] ^ h[9];
  endfunction

  assign ks_bit = kf(kcnt);

  always @(posedge clk) begin
    if (!rst_n) bnow <= '0;
    else if (tick) bnow <= bnow + 1'b1;
    if (rst_n && ks_adv) kcnt <= kcnt + 1;
    if (rst_n && (frame_valid || frame_error)) begin
      nstb <= nstb + 1;
      cv <= frame_valid; ce <= frame_error;
      cw <= frame_word; cl <= frame_len; cs <= end_stamp;
    end
  end

  initial forever begin
    @(negedge clk);
    tick = (ph == 3);
    ph = (ph + 1) % 4;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (tick !== 1'b1);
      #1;
    end
  endtask

  task automatic do_arm();
    tk(1);
    arm = 1'b1;
    @(posedge clk); #1;
    arm = 1'b0;
  endtask

  // mode 0: long pulse end, 1: short interval end, 2: long pause end
  task automatic run_frame(input int d, input int nb, input int mode, input string tag);
    int kbase, s0, k0, p;
    logic [23:0] ew;
    logic [15:0] est;
    bit ev;
    kbase = kcnt; s0 = nstb;
    do_arm();
    tk(d);
    k0 = kbase + d / 21 + 1;
    ew = '0;
    for (int i = 0; i < nb; i++) begin
      p = 1 + $urandom % 4;
      if (p >= iv[i]) p = iv[i] - 1;
      carrier = 1'b0; tk(p);
      carrier = 1'b1; tk(iv[i] - p);
      if (i < 24) ew[i] = (iv[i] > 17) ^ kf(k0 + i);
    end
    carrier = 1'b0; est = bnow + 16'd2;
    if (mode == 0) begin
      tk(4); carrier = 1'b1; tk(40);
    end else if (mode == 1) begin
      tk(1); carrier = 1'b1; tk(2);
      carrier = 1'b0; est = bnow + 16'd2;
      tk(1); carrier = 1'b1; tk(10);
    end else begin
      tk(40); carrier = 1'b1; tk(5);
    end
    ev = (nb >= 6 && nb <= 23);
    chk(nstb == s0 + 1, {tag, " R11 one strobe"}, nstb - s0, 1);
    chk(cv == ev, {tag, " R8 valid"}, cv, ev);
    chk(ce == !ev, {tag, " R8 error"}, ce, !ev);
    chk(cl == 5'(nb), {tag, " R8 len"}, cl, nb);
    chk(cw == ew, {tag, " R4 R5 word"}, cw, ew);
    chk(cs == est, {tag, mode == 1 ? " R7 R9 stamp" : " R6 R9 stamp"}, cs, est);
    chk(kcnt - kbase == d / 21 + 1 + nb, {tag, " R2 R5 advances"}, kcnt - kbase, d / 21 + 1 + nb);
  endtask

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) iv[i] = 4 + $urandom % 28;
  endtask

  initial begin
    int k0, s0;
    logic [15:0] st0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    // R1
    chk(ks_adv == 0 && frame_valid == 0 && frame_error == 0, "R1 strobes", {ks_adv, frame_valid, frame_error}, 0);
    chk(frame_word == 0 && frame_len == 0 && end_stamp == 0, "R1 outputs", frame_word, 0);
    rst_n = 1'b1;

    // R10: pauses while idle
    k0 = kcnt; s0 = nstb;
    for (int i = 0; i < 5; i++) begin carrier = 1'b0; tk(4); carrier = 1'b1; tk(9); end
    tk(40);
    chk(nstb == s0, "R10 no strobe", nstb - s0, 0);
    chk(kcnt == k0, "R10 no advance", kcnt - k0, 0);

    // R4 boundaries
    iv[0]=17; iv[1]=18; iv[2]=4; iv[3]=31; iv[4]=13; iv[5]=21; iv[6]=5; iv[7]=30;
    run_frame(10, 8, 0, "dir_bounds");
    // R8 length limits
    fill_rand(5);  run_frame(3, 5, 0, "len5");
    fill_rand(6);  run_frame(21, 6, 0, "len6");
    fill_rand(23); run_frame(42, 23, 0, "len23");
    fill_rand(24); run_frame(7, 24, 0, "len24");
    // R7 short interval end
    fill_rand(9);  run_frame(15, 9, 1, "short9");
    fill_rand(3);  run_frame(15, 3, 1, "short3");
    // R6 long pause end
    fill_rand(7);  run_frame(20, 7, 2, "longpause");
    // R2 long wait
    fill_rand(10); run_frame(21 * 50 + 7, 10, 0, "longwait");

    for (int n = 0; n < 16; n++) begin
      int nb;
      nb = 6 + $urandom % 18;
      fill_rand(nb);
      run_frame(1 + $urandom % 200, nb, $urandom % 3, "rand");
    end

    // R3 timeout
    k0 = kcnt; s0 = nstb; st0 = end_stamp;
    do_arm();
    tk(2600);
    chk(nstb == s0 + 1 && ce == 1 && cv == 0, "R3 error strobe", {cv, ce}, 1);
    chk(cl == 0, "R3 len", cl, 0);
    chk(cs == st0, "R3 stamp kept", cs, st0);
    chk(kcnt - k0 == 122, "R3 advances", kcnt - k0, 122);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule